// File: doc/BRIEF.md
# Video Controller CPU Register Interface

This block is the processor-facing register file of a picture-processing unit. The host issues single-byte requests to eight registers, picked by a 3-bit index. The registers hold control and mask bytes, a status byte, a sprite-attribute pointer and a 256-byte sprite-attribute memory. A two-write sequencer assembles a 15-bit temporary video address and a 3-bit fine horizontal scroll. The sequencer then commits the temporary address into a 15-bit current address. The rendering side receives the control byte, the mask byte, both addresses and fine-X as plain outputs. It feeds the vertical-blank set pulse and the two live status flags back in.

Requests use a valid/ready handshake. `req_ready` is always high, so the block never applies back-pressure and takes one request in every cycle that `req_valid` is high. A read's response appears on `rsp_data` with `rsp_valid` high for exactly one cycle, in the cycle after the request is accepted. The response channel has no ready: the host must take it in that cycle. Every accepted write, and every status or sprite-data read, refreshes a data latch. A read of any other register returns that latch.

Top module: `vid_cpu_regs`

## Requirements
- R1: After synchronous reset the following are all zero: `ctrl_q`, `mask_q`, `tmp_addr`, `cur_addr`, `fine_x`, the sprite pointer, the two-write toggle, the blank flag, the data latch and `rsp_valid`.
- R2: `req_ready` is always 1. Each accepted read (`req_valid`=1, `req_write`=0) gives `rsp_valid`=1 in exactly the next cycle with its data. Writes give no response.
- R3: A write to index 0 (control) loads `ctrl_q` with the byte and copies byte bits 1:0 into `tmp_addr[11:10]`. No other `tmp_addr` bit changes.
- R4: A write to index 5 (scroll) with the toggle clear loads `fine_x` from byte bits 2:0 and `tmp_addr[4:0]` from byte bits 7:3, then sets the toggle.
- R5: A write to index 5 with the toggle set loads `tmp_addr[14:12]` from byte bits 2:0 and `tmp_addr[9:5]` from byte bits 7:3, then clears the toggle.
- R6: A write to index 6 (address) with the toggle clear loads `tmp_addr[13:8]` from byte bits 5:0, clears `tmp_addr[14]` and sets the toggle. `cur_addr` is unchanged.
- R7: A write to index 6 with the toggle set loads `tmp_addr[7:0]`, copies the full result into `cur_addr` and clears the toggle. `cur_addr` changes on no other event.
- R8: A read of index 2 (status) returns {blank, `hit_flag`, `ovf_flag`, 5'b0}, then clears blank and the toggle. A `blank_set` pulse in the same cycle leaves blank set.
- R9: A write to index 3 loads the sprite pointer. A write to index 4 stores the byte at the pointer and increments the pointer modulo 256.
- R10: A read of index 4 returns the byte at the pointer and leaves the pointer unchanged.
- R11: Every write loads the data latch with the written byte, and status and sprite-data reads load it with the returned byte. A read of index 0, 1, 3, 5, 6 or 7 returns the latch and leaves it unchanged.
- R12: A write to index 1 loads `mask_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_idx | input | 3 | Register index |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read response present for one cycle |
| rsp_data | output | 8 | Read response byte |
| blank_set | input | 1 | Pulse that sets the blank flag |
| hit_flag | input | 1 | Live status bit 6 |
| ovf_flag | input | 1 | Live status bit 5 |
| ctrl_q | output | 8 | Control register |
| mask_q | output | 8 | Mask register |
| tmp_addr | output | 15 | Temporary video address |
| cur_addr | output | 15 | Current video address |
| fine_x | output | 3 | Fine horizontal scroll |

## Verification
The bench sends a scroll pair and then an address pair through the same toggle. A design with separate toggles, or with misplaced bit fields, would leave the wrong `tmp_addr` after the second write. A status read placed between two address writes must restart the sequence, or the high address byte would land in the low byte. The bench wraps the sprite pointer from 255 to 0 and reads sprite data twice: an increment on read would return the next byte, and an unwrapped pointer would miss the wrapped store. Reads of write-only registers must echo the last transferred byte. A status read must not lose a blank pulse that arrives in the same cycle.

// File: rtl/vcr_pkg.sv
package vcr_pkg;
  localparam int DW = 8;
  localparam int VAW = 15;

  typedef enum logic [2:0] {
    IX_CTRL   = 3'd0,
    IX_MASK   = 3'd1,
    IX_STATUS = 3'd2,
    IX_SPTR   = 3'd3,
    IX_SDATA  = 3'd4,
    IX_SCROLL = 3'd5,
    IX_ADDR   = 3'd6,
    IX_DATA   = 3'd7
  } vcr_idx_e;

  typedef struct packed {
    logic wr_ctrl;
    logic wr_mask;
    logic wr_sptr;
    logic wr_sdata;
    logic wr_scroll;
    logic wr_addr;
    logic wr_any;
    logic rd_status;
    logic rd_sdata;
    logic rd_any;
  } vcr_strobe_t;
endpackage

// File: rtl/vcr_decode.sv
module vcr_decode
  import vcr_pkg::*;
(
  input  logic        acc_valid,
  input  logic        acc_write,
  input  logic [2:0]  acc_idx,
  output vcr_strobe_t stb
);
  vcr_idx_e ix;
  logic wr, rd;

  always_comb begin
    ix = vcr_idx_e'(acc_idx);
    wr = acc_valid && acc_write;
    rd = acc_valid && !acc_write;
    stb = '0;
    stb.wr_any    = wr;
    stb.rd_any    = rd;
    stb.wr_ctrl   = wr && (ix == IX_CTRL);
    stb.wr_mask   = wr && (ix == IX_MASK);
    stb.wr_sptr   = wr && (ix == IX_SPTR);
    stb.wr_sdata  = wr && (ix == IX_SDATA);
    stb.wr_scroll = wr && (ix == IX_SCROLL);
    stb.wr_addr   = wr && (ix == IX_ADDR);
    stb.rd_status = rd && (ix == IX_STATUS);
    stb.rd_sdata  = rd && (ix == IX_SDATA);
  end
endmodule

// File: rtl/vcr_scroll_addr.sv
module vcr_scroll_addr
  import vcr_pkg::*;
#(
  parameter int AW = VAW,
  parameter int FXW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_ctrl,
  input  logic          wr_scroll,
  input  logic          wr_addr,
  input  logic          rd_status,
  input  logic [DW-1:0] wdata,
  output logic [AW-1:0] tmp_q,
  output logic [AW-1:0] cur_q,
  output logic [FXW-1:0] fx_q,
  output logic          tgl_q
);
  logic [AW-1:0] tmp_n;

  always_comb begin
    tmp_n = tmp_q;
    if (wr_ctrl) begin
      tmp_n[11:10] = wdata[1:0];
    end else if (wr_scroll && !tgl_q) begin
      tmp_n[4:0] = wdata[7:3];
    end else if (wr_scroll && tgl_q) begin
      tmp_n[14:12] = wdata[2:0];
      tmp_n[9:5]   = wdata[7:3];
    end else if (wr_addr && !tgl_q) begin
      tmp_n[14]   = 1'b0;
      tmp_n[13:8] = wdata[5:0];
    end else if (wr_addr && tgl_q) begin
      tmp_n[7:0] = wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tmp_q <= '0;
      cur_q <= '0;
      fx_q  <= '0;
      tgl_q <= 1'b0;
    end else begin
      tmp_q <= tmp_n;
      if (wr_scroll && !tgl_q) fx_q <= wdata[FXW-1:0];
      if (wr_addr && tgl_q) cur_q <= tmp_n;
      if (rd_status) tgl_q <= 1'b0;
      else if (wr_scroll || wr_addr) tgl_q <= !tgl_q;
    end
  end

  AST_CUR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(wr_addr && tgl_q) |=> $stable(cur_q)); // R7
  AST_STATUS_TGL_CLR: assert property (@(posedge clk) disable iff (rst)
    rd_status |=> !tgl_q); // R8
  AST_TGL_FLIP: assert property (@(posedge clk) disable iff (rst)
    (wr_scroll || wr_addr) |=> (tgl_q != $past(tgl_q))); // R4
  AST_ADDR_B14: assert property (@(posedge clk) disable iff (rst)
    (wr_addr && !tgl_q) |=> !tmp_q[14]); // R6
endmodule

// File: rtl/vcr_spr_ram.sv
module vcr_spr_ram
  import vcr_pkg::*;
#(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_ptr,
  input  logic          wr_data,
  input  logic          rd_data,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rbyte
);
  localparam int DEPTH = 1 << PW;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] ptr_q;

  assign rbyte = mem[ptr_q];

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (wr_ptr) begin
      ptr_q <= wdata[PW-1:0];
    end else if (wr_data) begin
      ptr_q <= ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_data) mem[ptr_q] <= wdata;
  end

  AST_SPR_INC: assert property (@(posedge clk) disable iff (rst)
    wr_data |=> (ptr_q == $past(ptr_q) + 1'b1)); // R9
  AST_SPR_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    rd_data |=> $stable(ptr_q)); // R10
endmodule

// File: rtl/vid_cpu_regs.sv
module vid_cpu_regs
  import vcr_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [2:0]  req_idx,
  input  logic [7:0]  req_wdata,
  output logic        rsp_valid,
  output logic [7:0]  rsp_data,
  input  logic        blank_set,
  input  logic        hit_flag,
  input  logic        ovf_flag,
  output logic [7:0]  ctrl_q,
  output logic [7:0]  mask_q,
  output logic [14:0] tmp_addr,
  output logic [14:0] cur_addr,
  output logic [2:0]  fine_x
);
  vcr_strobe_t stb;
  logic [DW-1:0] spr_byte;
  logic [DW-1:0] stat_byte;
  logic [DW-1:0] rd_byte;
  logic [DW-1:0] obus_q;
  logic          blank_q;
  logic          tgl;

  assign req_ready = 1'b1;

  vcr_decode u_dec (
    .acc_valid (req_valid),
    .acc_write (req_write),
    .acc_idx   (req_idx),
    .stb       (stb)
  );

  vcr_scroll_addr #(.AW(VAW), .FXW(3)) u_sa (
    .clk       (clk),
    .rst       (rst),
    .wr_ctrl   (stb.wr_ctrl),
    .wr_scroll (stb.wr_scroll),
    .wr_addr   (stb.wr_addr),
    .rd_status (stb.rd_status),
    .wdata     (req_wdata),
    .tmp_q     (tmp_addr),
    .cur_q     (cur_addr),
    .fx_q      (fine_x),
    .tgl_q     (tgl)
  );

  vcr_spr_ram #(.PW(8)) u_spr (
    .clk     (clk),
    .rst     (rst),
    .wr_ptr  (stb.wr_sptr),
    .wr_data (stb.wr_sdata),
    .rd_data (stb.rd_sdata),
    .wdata   (req_wdata),
    .rbyte   (spr_byte)
  );

  always_comb begin
    stat_byte = {blank_q, hit_flag, ovf_flag, 5'b0};
    if (stb.rd_status)     rd_byte = stat_byte;
    else if (stb.rd_sdata) rd_byte = spr_byte;
    else                   rd_byte = obus_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      mask_q    <= '0;
      blank_q   <= 1'b0;
      obus_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= stb.rd_any;
      if (stb.rd_any) rsp_data <= rd_byte;
      if (stb.wr_ctrl) ctrl_q <= req_wdata;
      if (stb.wr_mask) mask_q <= req_wdata;
      if (blank_set) blank_q <= 1'b1;
      else if (stb.rd_status) blank_q <= 1'b0;
      if (stb.wr_any) obus_q <= req_wdata;
      else if (stb.rd_status || stb.rd_sdata) obus_q <= rd_byte;
    end
  end

  AST_RSP_FROM_READ: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid && !req_write)); // R2
  AST_BUS_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write) |=> (obus_q == $past(req_wdata))); // R11
  AST_BLANK_CLR: assert property (@(posedge clk) disable iff (rst)
    (stb.rd_status && !blank_set) |=> !blank_q); // R8
  AST_BLANK_SET: assert property (@(posedge clk) disable iff (rst)
    blank_set |=> blank_q); // R8
endmodule

// File: tb/test_vid_cpu_regs.sv
module test_vid_cpu_regs;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_write, req_ready;
  logic [2:0]  req_idx;
  logic [7:0]  req_wdata;
  logic        rsp_valid;
  logic [7:0]  rsp_data;
  logic        blank_set, hit_flag, ovf_flag;
  logic [7:0]  ctrl_q, mask_q;
  logic [14:0] tmp_addr, cur_addr;
  logic [2:0]  fine_x;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  logic [7:0]  exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  vid_cpu_regs i_vid_cpu_regs (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_idx(req_idx), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .blank_set(blank_set), .hit_flag(hit_flag), .ovf_flag(ovf_flag),
    .ctrl_q(ctrl_q), .mask_q(mask_q), .tmp_addr(tmp_addr),
    .cur_addr(cur_addr), .fine_x(fine_x)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] idx, logic [7:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_idx = idx; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    check("R2 no response to write", rsp_valid, 0);
  endtask

  task automatic rd(logic [2:0] idx, logic [7:0] exp, string req, bit with_blank = 0);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_idx = idx; blank_set = with_blank;
    exp_q.push_back(exp);
    tag_q.push_back(req);
    @(negedge clk);
    req_valid = 0; blank_set = 0;
  endtask

  // monitor: pop expected read data as responses appear
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (exp_q.size() == 0) begin
        vectors++; miscompares++;
        $display("FAIL R2 unexpected response actual=%0h expected=none", rsp_data);
      end else begin
        check(tag_q.pop_front(), rsp_data, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst = 1; req_valid = 0; req_write = 0; req_idx = 0; req_wdata = 0;
    blank_set = 0; hit_flag = 0; ovf_flag = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1 ctrl", ctrl_q, 0);
    check("R1 mask", mask_q, 0);
    check("R1 tmp", tmp_addr, 0);
    check("R1 cur", cur_addr, 0);
    check("R1 fine_x", fine_x, 0);
    check("R1 rsp_valid", rsp_valid, 0);
    check("R2 ready", req_ready, 1);
    rd(3'd2, 8'h00, "R1 status after reset");
    rd(3'd0, 8'h00, "R1 latch after reset");

    // R3 control
    wr(3'd0, 8'h03);
    check("R3 ctrl", ctrl_q, 8'h03);
    check("R3 tmp", tmp_addr, 15'h0C00);
    // R12 mask, R11 latch readback
    wr(3'd1, 8'h1E);
    check("R12 mask", mask_q, 8'h1E);
    rd(3'd1, 8'h1E, "R11 read mask returns latch");

    // R4/R5 scroll pair
    wr(3'd5, 8'h7D);
    check("R4 fine_x", fine_x, 3'd5);
    check("R4 tmp", tmp_addr, 15'h0C0F);
    wr(3'd5, 8'h5E);
    check("R5 tmp", tmp_addr, 15'h6D6F);
    check("R5 fine_x kept", fine_x, 3'd5);
    check("R7 cur unchanged by scroll", cur_addr, 0);

    // R6/R7 address pair
    wr(3'd6, 8'hFF);
    check("R6 tmp", tmp_addr, 15'h3F6F);
    check("R6 cur unchanged", cur_addr, 0);
    wr(3'd6, 8'h21);
    check("R7 tmp", tmp_addr, 15'h3F21);
    check("R7 cur", cur_addr, 15'h3F21);

    // R8 status read resets toggle and blank
    hit_flag = 1;
    @(negedge clk); blank_set = 1; @(negedge clk); blank_set = 0;
    wr(3'd6, 8'h12);
    rd(3'd2, 8'hC0, "R8 status with blank");
    rd(3'd2, 8'h40, "R8 blank cleared");
    wr(3'd6, 8'h05);
    check("R8 toggle reset tmp", tmp_addr, 15'h0521);
    check("R8 cur held", cur_addr, 15'h3F21);
    wr(3'd6, 8'h34);
    check("R7 cur second", cur_addr, 15'h0534);
    // R8 set wins over clear in same cycle
    rd(3'd2, 8'h40, "R8 read during set pulse", 1);
    rd(3'd2, 8'hC0, "R8 set survives clear");
    hit_flag = 0; ovf_flag = 1;
    rd(3'd2, 8'h20, "R8 overflow bit");
    ovf_flag = 0;

    // R9/R10 sprite memory
    wr(3'd3, 8'hFE);
    wr(3'd4, 8'hAA);
    wr(3'd4, 8'hBB);
    wr(3'd4, 8'hCC);
    wr(3'd3, 8'hFF);
    rd(3'd4, 8'hBB, "R10 sprite read");
    rd(3'd4, 8'hBB, "R10 no increment on read");
    wr(3'd4, 8'hDD);
    rd(3'd4, 8'hCC, "R9 wrap to zero");
    wr(3'd3, 8'hFE);
    rd(3'd4, 8'hAA, "R9 stored at pointer");

    // R11 open-bus latch
    rd(3'd0, 8'hAA, "R11 ctrl read returns latch");
    rd(3'd7, 8'hAA, "R11 data read returns latch");
    wr(3'd7, 8'h5A);
    rd(3'd5, 8'h5A, "R11 write loads latch");
    rd(3'd3, 8'h5A, "R11 latch unchanged by plain read");
    rd(3'd2, 8'h00, "R8 status clear");
    rd(3'd6, 8'h00, "R11 status read loads latch");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      vectors++; miscompares++;
      $display("FAIL R2 missing responses actual=%0d expected=0", exp_q.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule